// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a full-duplex SPI master run from a 32-bit register interface. Software pushes words into a transmit FIFO through the data register. It sets the word length, the clock mode, the bit order and the chip select in two control words, and it picks the serial clock rate with an 8-bit divider. Each transmitted word produces one received word, which software pops from the same data register.

A chip-select sequencer drives two select pins, and each pin has its own active level. The chosen select stays asserted for as long as words remain in the transmit FIFO. When the "hold" control bit is set, the select also stays asserted after the FIFO drains. When the FIFO has drained and the hold bit is clear, the select is released and an end-of-transfer status bit sets. Status flags report the FIFO levels, a transmit underrun while the select is held, and receive overrun. An internal loopback path feeds the transmitted bits back into the receiver.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the control 0, control 1 and divider registers read 0. The status register (0x0C) reads 0x10 (only the RX-empty flag, bit 4, is set). Both chip-select pins are high and the serial clock is low.
- R2: Registers are at byte offsets 0x00 (data), 0x04 (control 0), 0x08 (control 1), 0x0C (status) and 0x18 (divider). Control 1 reads back as written in bits 31, 30, 23, 7:3, 1 and 0. The divider keeps only bits 7:0.
- R3: While a frame shifts, the serial clock period is 2×(divider+1) input clock cycles.
- R4: Control 1 bits 7:3 hold the word length minus two, which gives lengths of 2 to 32 bits. Loopback is control 0 bit 10. With loopback on and matching bit orders, each received word equals the transmitted word masked to its length, right-aligned and zero-extended.
- R5: Control 0 bit 19 sends words LSB first and bit 17 receives words LSB first; otherwise words go MSB first. If the two orders differ, loopback returns the word bit-reversed within its length.
- R6: Control 1 bit 0 (clock polarity) sets the idle level of the serial clock. Control 1 bit 1 (clock phase) selects whether data is sampled on the first or the second clock edge. Loopback data is correct in all four modes.
- R7: Control 0 bit 6 selects chip select 1 instead of 0. Control 1 bit 30 (select 0) and bit 31 (select 1) make a select active high. A select pin shows its active level only while a transfer runs; otherwise it shows its inactive level.
- R8: While control 1 bit 23 (hold) is set, the selected chip select stays asserted between frames and after the TX FIFO drains. Once the bit is clear and the FIFO is drained, the select is released and status bit 7 (end) sets. A new frame clears status bit 7.
- R9: Status bit 1 (underrun) sets when a frame ends with the TX FIFO empty and hold set. A status write with bit 1 at 0 clears it.
- R10: A frame that ends while the 128-entry RX FIFO is full has its word dropped, and status bit 0 (overrun) sets. A status write with bit 0 at 0 clears it.
- R11: Status bit 5 reads 1 when the TX FIFO holds 128 words. Status bit 4 reads 1 when the RX FIFO is empty. Status bit 2 reads 1 when the RX FIFO holds 64 or more words.
- R12: Writing 1 to control 0 bit 2 empties the TX FIFO, and writing 1 to bit 1 empties the RX FIFO. Both bits read back as 0.
- R13: While control 0 bit 15 (enable) is 0, no frame starts, even if the TX FIFO holds data.
- R14: With loopback off, received bits come from the serial input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 2 | Chip-select pins, one per device |

## Verification
Loopback words are sent at lengths 2, 8, 17 and 32 bits under each of the four clock modes. These runs separate errors in length masking from errors in sample and shift edge timing. Mixed and matched bit orders separate the transmit order from the receive order. Two constant patterns on the serial input pin show whether the receiver reads the pin or the loopback path. A hold-mode transfer and a fill of 129 words through a 2-bit frame exercise the chip-select hold, underrun, end, full, half-full and overrun flags.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register byte offsets
  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_CTL0 = 5'h04;
  localparam logic [4:0] OFS_CTL1 = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_DIV  = 5'h18;

  // control 0 bit positions
  localparam int C0_TXLSB = 19;
  localparam int C0_RXLSB = 17;
  localparam int C0_EN    = 15;
  localparam int C0_LOOP  = 10;
  localparam int C0_CSEL  = 6;
  localparam int C0_TFL   = 2;
  localparam int C0_RFL   = 1;

  // control 1 bit positions
  localparam int C1_CS1HI = 31;
  localparam int C1_CS0HI = 30;
  localparam int C1_HOLD  = 23;
  localparam int C1_LENLO = 3;
  localparam int C1_PHA   = 1;
  localparam int C1_POL   = 0;

  // status bit positions
  localparam int S_END  = 7;
  localparam int S_BUSY = 6;
  localparam int S_TFF  = 5;
  localparam int S_RFE  = 4;
  localparam int S_RFHF = 2;
  localparam int S_UNDR = 1;
  localparam int S_OVER = 0;

  typedef struct packed {
    logic       pol;
    logic       pha;
    logic       tx_lsb;
    logic       rx_lsb;
    logic       loop;
    logic [4:0] flen;
    logic [7:0] div;
  } shift_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         empty,
  output logic                         full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_nx, rp_q, rp_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_nx  = wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    if (flush) begin
      wp_nx  = '0;
      rp_nx  = '0;
      cnt_nx = '0;
    end else begin
      if (do_push) wp_nx = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_nx = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_nx = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  shift_cfg_t    cfg,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi
);
  localparam int unsigned LW = $clog2(DW);
  localparam int unsigned NW = LW + 1;
  localparam int unsigned HW = LW + 2;

  logic          busy_q, busy_nx, done_q, done_nx;
  logic          pha_q, pha_nx, txlsb_q, txlsb_nx, rxlsb_q, rxlsb_nx, loop_q, loop_nx;
  logic [7:0]    dcnt_q, dcnt_nx;
  logic [HW-1:0] half_q, half_nx, half_inc, half_last;
  logic [NW-1:0] nbits_q, nbits_nx;
  logic [DW-1:0] tx_q, tx_nx, rx_q, rx_nx, rxw_q, rxw_nx;
  logic [LW-1:0] msb_idx;
  logic          tick, rx_bit, is_sample;

  assign msb_idx   = LW'(nbits_q - 1'b1);
  assign mosi      = txlsb_q ? tx_q[0] : tx_q[msb_idx];
  assign rx_bit    = loop_q ? mosi : miso;
  assign tick      = busy_q && (dcnt_q == cfg.div);
  assign half_inc  = half_q + 1'b1;
  assign half_last = pha_q ? HW'({nbits_q, 1'b0}) : HW'({nbits_q, 1'b0}) - 1'b1;
  assign is_sample = half_inc[0] ^ pha_q;

  always_comb begin
    busy_nx  = busy_q;
    done_nx  = 1'b0;
    pha_nx   = pha_q;
    txlsb_nx = txlsb_q;
    rxlsb_nx = rxlsb_q;
    loop_nx  = loop_q;
    dcnt_nx  = dcnt_q;
    half_nx  = half_q;
    nbits_nx = nbits_q;
    tx_nx    = tx_q;
    rx_nx    = rx_q;
    rxw_nx   = rxw_q;
    if (start && !busy_q) begin
      busy_nx  = 1'b1;
      dcnt_nx  = '0;
      half_nx  = '0;
      nbits_nx = NW'(cfg.flen) + NW'(2);
      pha_nx   = cfg.pha;
      txlsb_nx = cfg.tx_lsb;
      rxlsb_nx = cfg.rx_lsb;
      loop_nx  = cfg.loop;
      tx_nx    = tx_word;
      rx_nx    = '0;
    end else if (busy_q) begin
      if (tick) begin
        dcnt_nx = '0;
        if (half_q == half_last) begin
          busy_nx = 1'b0;
          done_nx = 1'b1;
          rxw_nx  = rx_q;
        end else begin
          half_nx = half_inc;
          if (is_sample) begin
            rx_nx = rxlsb_q ? ((rx_q >> 1) | (DW'(rx_bit) << msb_idx))
                            : {rx_q[DW-2:0], rx_bit};
          end else if (half_inc >= HW'(2)) begin
            tx_nx = txlsb_q ? (tx_q >> 1) : (tx_q << 1);
          end
        end
      end else begin
        dcnt_nx = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pha_q   <= 1'b0;
      txlsb_q <= 1'b0;
      rxlsb_q <= 1'b0;
      loop_q  <= 1'b0;
      dcnt_q  <= '0;
      half_q  <= '0;
      nbits_q <= NW'(2);
      tx_q    <= '0;
      rx_q    <= '0;
      rxw_q   <= '0;
    end else begin
      busy_q  <= busy_nx;
      done_q  <= done_nx;
      pha_q   <= pha_nx;
      txlsb_q <= txlsb_nx;
      rxlsb_q <= rxlsb_nx;
      loop_q  <= loop_nx;
      dcnt_q  <= dcnt_nx;
      half_q  <= half_nx;
      nbits_q <= nbits_nx;
      tx_q    <= tx_nx;
      rx_q    <= rx_nx;
      rxw_q   <= rxw_nx;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rxw_q;
  assign sclk    = cfg.pol ^ (busy_q & half_q[0]);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned FIFO_DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [1:0]  cs_pin
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          en_q, loop_q, csel_q, txlsb_q, rxlsb_q;
  logic          pol_q, pha_q, hold_q;
  logic [1:0]    cshi_q;
  logic [4:0]    flen_q;
  logic [7:0]    div_q;
  logic          end_q, end_nx, undr_q, undr_nx, over_q, over_nx, cs_on_q, cs_on_nx;
  logic          wr_en, rd_en, wr_ctl0, wr_ctl1, wr_stat, wr_div;
  logic          tx_push, rx_pop, tx_flush, rx_flush;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head, sh_rx;
  logic          sh_busy, sh_done, start, release_cs;
  shift_cfg_t    cfg;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign wr_ctl0  = wr_en && (bus_addr == OFS_CTL0);
  assign wr_ctl1  = wr_en && (bus_addr == OFS_CTL1);
  assign wr_stat  = wr_en && (bus_addr == OFS_STAT);
  assign wr_div   = wr_en && (bus_addr == OFS_DIV);
  assign tx_push  = wr_en && (bus_addr == OFS_DATA);
  assign rx_pop   = rd_en && (bus_addr == OFS_DATA);
  assign tx_flush = wr_ctl0 && bus_wdata[C0_TFL];
  assign rx_flush = wr_ctl0 && bus_wdata[C0_RFL];

  assign cfg = '{pol: pol_q, pha: pha_q, tx_lsb: txlsb_q, rx_lsb: rxlsb_q,
                 loop: loop_q, flen: flen_q, div: div_q};

  spim_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n), .flush(tx_flush), .push(tx_push),
    .wdata(bus_wdata[DW-1:0]), .pop(start), .rdata(tx_head), .cnt(tx_cnt),
    .empty(tx_empty), .full(tx_full));

  spim_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n), .flush(rx_flush), .push(sh_done),
    .wdata(sh_rx), .pop(rx_pop), .rdata(rx_head), .cnt(rx_cnt),
    .empty(rx_empty), .full(rx_full));

  spim_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .start(start), .tx_word(tx_head), .cfg(cfg),
    .miso(miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
    .sclk(sclk), .mosi(mosi));

  // chip-select sequencing
  assign start      = en_q && !sh_busy && !tx_empty;
  assign release_cs = cs_on_q && !sh_busy && !start && !hold_q;

  always_comb begin
    cs_on_nx = cs_on_q;
    end_nx   = end_q;
    if (start) begin
      cs_on_nx = 1'b1;
      end_nx   = 1'b0;
    end else if (release_cs) begin
      cs_on_nx = 1'b0;
      end_nx   = 1'b1;
    end
    undr_nx = wr_stat ? (undr_q & bus_wdata[S_UNDR]) : undr_q;
    over_nx = wr_stat ? (over_q & bus_wdata[S_OVER]) : over_q;
    if (sh_done && tx_empty && hold_q) undr_nx = 1'b1;
    if (sh_done && rx_full)            over_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q <= 1'b0; loop_q <= 1'b0; csel_q <= 1'b0; txlsb_q <= 1'b0; rxlsb_q <= 1'b0;
      pol_q <= 1'b0; pha_q <= 1'b0; hold_q <= 1'b0; cshi_q <= 2'b00; flen_q <= '0;
      div_q <= '0; end_q <= 1'b0; undr_q <= 1'b0; over_q <= 1'b0; cs_on_q <= 1'b0;
    end else begin
      if (wr_ctl0) begin
        en_q    <= bus_wdata[C0_EN];
        loop_q  <= bus_wdata[C0_LOOP];
        csel_q  <= bus_wdata[C0_CSEL];
        txlsb_q <= bus_wdata[C0_TXLSB];
        rxlsb_q <= bus_wdata[C0_RXLSB];
      end
      if (wr_ctl1) begin
        pol_q  <= bus_wdata[C1_POL];
        pha_q  <= bus_wdata[C1_PHA];
        hold_q <= bus_wdata[C1_HOLD];
        cshi_q <= {bus_wdata[C1_CS1HI], bus_wdata[C1_CS0HI]};
        flen_q <= bus_wdata[C1_LENLO +: 5];
      end
      if (wr_div) div_q <= bus_wdata[7:0];
      end_q   <= end_nx;
      undr_q  <= undr_nx;
      over_q  <= over_nx;
      cs_on_q <= cs_on_nx;
    end
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cs
      assign cs_pin[i] = (cs_on_q && (csel_q == 1'(i))) ? cshi_q[i] : ~cshi_q[i];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_DATA: bus_rdata = 32'(rx_head);
      OFS_CTL0: begin
        bus_rdata[C0_TXLSB] = txlsb_q;
        bus_rdata[C0_RXLSB] = rxlsb_q;
        bus_rdata[C0_EN]    = en_q;
        bus_rdata[C0_LOOP]  = loop_q;
        bus_rdata[C0_CSEL]  = csel_q;
      end
      OFS_CTL1: begin
        bus_rdata[C1_CS1HI]         = cshi_q[1];
        bus_rdata[C1_CS0HI]         = cshi_q[0];
        bus_rdata[C1_HOLD]          = hold_q;
        bus_rdata[C1_LENLO +: 5]    = flen_q;
        bus_rdata[C1_PHA]           = pha_q;
        bus_rdata[C1_POL]           = pol_q;
      end
      OFS_STAT: begin
        bus_rdata[S_END]  = end_q;
        bus_rdata[S_BUSY] = sh_busy;
        bus_rdata[S_TFF]  = tx_full;
        bus_rdata[S_RFE]  = rx_empty;
        bus_rdata[S_RFHF] = (rx_cnt >= CW'(FIFO_DEPTH/2));
        bus_rdata[S_UNDR] = undr_q;
        bus_rdata[S_OVER] = over_q;
      end
      OFS_DIV:  bus_rdata[7:0] = div_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sh_busy,
  input logic [1:0]    cs_pin,
  input logic          end_flag,
  input logic          undr_flag,
  input logic          cs_on,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          sclk,
  input logic          pol
);
  // R7
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && $past(sh_busy)) |-> $stable(cs_pin));

  // R8
  end_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> (!sh_busy && !cs_on));

  // R9
  undr_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undr_flag) |-> cs_on);

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_busy && !$past(sh_busy)) |-> (sclk == pol));
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_busy(sh_busy), .cs_pin(cs_pin),
  .end_flag(end_q), .undr_flag(undr_q), .cs_on(cs_on_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sclk(sclk), .pol(pol_q));

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
  import spim_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, miso = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic [1:0]  cs_pin;

  int n_chk = 0, n_fail = 0, cyc = 0, cs0_rise = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  spim_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pin(cs_pin));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge cs_pin[0]) cs0_rise <= cs0_rise + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input int len, input bit rev);
    logic [31:0] m, e, r;
    m = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    e = w & m;
    r = '0;
    for (int i = 0; i < len; i++) r[i] = e[len-1-i];
    return rev ? r : e;
  endfunction

  // driver: records the expected received word, then pushes the TX word
  task automatic send(input logic [31:0] w, input int len, input bit rev);
    exp_q.push_back(expect_word(w, len, rev));
    wr(OFS_DATA, w);
  endtask

  // monitor: pops RX words while any are present and compares with the scoreboard
  task automatic drain(input string tag);
    logic [31:0] s, d;
    rd(OFS_STAT, s);
    while (!s[S_RFE]) begin
      rd(OFS_DATA, d);
      if (exp_q.size() == 0) check({tag, " unexpected word"}, d, 32'hDEAD_BEEF);
      else check(tag, d, exp_q.pop_front());
      rd(OFS_STAT, s);
    end
    check({tag, " scoreboard empty"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t0, t1, r0;
    gap(3);
    @(negedge clk) rst_n = 1'b1;
    gap(4);

    // R1 reset state
    rd(OFS_CTL0, v); check("R1 ctl0", v, 32'h0);
    rd(OFS_CTL1, v); check("R1 ctl1", v, 32'h0);
    rd(OFS_DIV, v);  check("R1 div", v, 32'h0);
    rd(OFS_STAT, v); check("R1 status", v, 32'h10);
    check("R1 cs pins", 32'(cs_pin), 32'h3);
    check("R1 sclk", 32'(sclk), 32'h0);

    // R2 register map and readback
    wr(OFS_CTL1, 32'hC080_0032);
    rd(OFS_CTL1, v); check("R2 ctl1 readback", v, 32'hC080_0032);
    wr(OFS_DIV, 32'h0000_01FF);
    rd(OFS_DIV, v); check("R2 div width", v, 32'h0000_00FF);
    wr(OFS_DIV, 32'h0);
    wr(OFS_CTL1, 32'h0000_0030);

    // R13 disabled block does not start; R12 TX flush
    wr(OFS_CTL0, 32'h0000_0400);
    wr(OFS_DATA, 32'h0000_005A);
    gap(40);
    rd(OFS_STAT, v); check("R13 no frame while disabled", v, 32'h10);
    check("R13 cs idle", 32'(cs_pin), 32'h3);
    wr(OFS_CTL0, 32'h0000_0404);
    rd(OFS_CTL0, v); check("R12 flush self-clear", v, 32'h0000_0400);
    wr(OFS_CTL0, 32'h0000_8400);
    gap(40);
    rd(OFS_STAT, v); check("R12 tx flushed, nothing sent", v, 32'h10);

    // R12 RX flush
    wr(OFS_DATA, 32'h0000_0077);
    gap(40);
    rd(OFS_STAT, v); check("R12 rx holds word", 32'(v[S_RFE]), 32'h0);
    wr(OFS_CTL0, 32'h0000_8402);
    rd(OFS_STAT, v); check("R12 rx flushed", 32'(v[S_RFE]), 32'h1);

    // R4 / R6 lengths and clock modes in loopback
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 4; li++) begin
        int len;
        len = (li == 0) ? 2 : (li == 1) ? 8 : (li == 2) ? 17 : 32;
        wr(OFS_CTL1, 32'(m) | (32'(len - 2) << 3));
        send(32'h9E37_79B9 ^ (32'(m) * 32'h1111_0000) ^ 32'(li), len, 1'b0);
        send(32'h6C8E_9CF5 ^ 32'(m * 7 + li), len, 1'b0);
        gap(200);
        check("R6 idle clock level", 32'(sclk), 32'(m & 1));
        drain("R4 loopback word");
      end
    end

    // R5 bit order
    wr(OFS_CTL1, 32'h0000_0030);
    wr(OFS_CTL0, 32'h0008_8400);
    send(32'h0000_0001, 8, 1'b1);
    send(32'h0000_00C4, 8, 1'b1);
    gap(60);
    drain("R5 tx lsb, rx msb reversed");
    wr(OFS_CTL0, 32'h000A_8400);
    send(32'h0000_00C4, 8, 1'b0);
    gap(40);
    drain("R5 both lsb first");

    // R3 clock period
    wr(OFS_CTL0, 32'h0000_8400);
    wr(OFS_DIV, 32'h3);
    fork
      send(32'h0000_00A5, 8, 1'b0);
      begin
        @(posedge sclk); t0 = cyc;
        @(posedge sclk); t1 = cyc;
      end
    join
    check("R3 sclk period", 32'(t1 - t0), 32'd8);
    gap(100);
    drain("R3 word");

    // R7 select 1, both selects active high
    wr(OFS_CTL1, 32'hC000_0030);
    wr(OFS_CTL0, 32'h0000_8440);
    check("R7 idle pins active-high polarity", 32'(cs_pin), 32'h0);
    send(32'h0000_003C, 8, 1'b0);
    gap(12);
    check("R7 select 1 asserted mid-frame", 32'(cs_pin), 32'h2);
    gap(100);
    check("R7 released after frame", 32'(cs_pin), 32'h0);
    drain("R7 word");

    // R8 / R9 hold across frames and underrun
    wr(OFS_DIV, 32'h0);
    wr(OFS_CTL1, 32'h0080_0030);
    wr(OFS_CTL0, 32'h0000_8400);
    r0 = cs0_rise;
    send(32'h0000_0011, 8, 1'b0);
    send(32'h0000_0022, 8, 1'b0);
    gap(60);
    check("R8 select held after drain", 32'(cs_pin), 32'h2);
    check("R8 no release between frames", 32'(cs0_rise - r0), 32'd0);
    rd(OFS_STAT, v); check("R9 underrun set, end clear", v & 32'hFF & ~32'h10, 32'h02);
    wr(OFS_CTL1, 32'h0000_0030);
    gap(3);
    check("R8 select released", 32'(cs_pin), 32'h3);
    rd(OFS_STAT, v); check("R8 end set", 32'(v[S_END]), 32'h1);
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, v); check("R9 underrun cleared", 32'(v[S_UNDR]), 32'h0);
    drain("R8 words");

    // R14 serial input path
    wr(OFS_CTL0, 32'h0000_8000);
    wr(OFS_CTL1, 32'h0000_0010);
    miso = 1'b1;
    exp_q.push_back(32'h0000_000F);
    wr(OFS_DATA, 32'h0000_0000);
    gap(30);
    miso = 1'b0;
    exp_q.push_back(32'h0000_0000);
    wr(OFS_DATA, 32'h0000_000F);
    gap(30);
    drain("R14 miso word");

    // R10 / R11 FIFO limits with 2-bit frames
    wr(OFS_CTL1, 32'h0000_0000);
    wr(OFS_CTL0, 32'h0000_0400);
    for (int i = 0; i < 128; i++) send(32'(i * 3 + 1), 2, 1'b0);
    rd(OFS_STAT, v); check("R11 tx full", 32'(v[S_TFF]), 32'h1);
    wr(OFS_CTL0, 32'h0000_8400);
    gap(1200);
    rd(OFS_STAT, v); check("R11 rx half full, not empty", v, 32'h84);
    wr(OFS_DATA, 32'h0000_0003);
    gap(20);
    rd(OFS_STAT, v); check("R10 overrun set", v, 32'h85);
    drain("R10 kept words");
    rd(OFS_STAT, v); check("R11 rx empty after drain", v, 32'h91);
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, v); check("R10 overrun cleared", v, 32'h90);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule